// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a digitized, active-low composite sync stream that has already been sliced and sampled on the system clock. From the spacing of ordinary horizontal sync pulses it learns the line period in clock cycles. It then uses that period to sort each sync pulse into narrow or broad. The first broad pulse of a vertical interval starts an active-low vertical sync pulse three line periods long.

Where that first broad pulse falls within the line tells the field apart. An interval that starts on a line boundary opens field 1. One that starts half a line later opens field 2. If successive intervals alternate in phase, the source is reported as interlaced and the field flag follows the phase. If they do not alternate, the source is treated as progressive and the field flag stays high. A lock flag reports that the vertical timing has been seen twice in a row. It drops again if the sync stream goes quiet.

Top module: `vsync_field_detector`

## Requirements
- R1: While reset is asserted and right after it is released, vsync_n is 1, field_odd is 1, interlaced is 0 and locked is 0.
- R2: The line period P is learned only when two successive measured gaps between sync falling edges, each ending at a narrow pulse, differ by no more than TOL cycles and are at least MIN_PERIOD. Before a period is learned, no pulse of any length starts vertical sync.
- R3: Once P is known, a pulse counts as broad when its low time exceeds P/4 cycles. vsync_n falls while that broad pulse is still low. Narrow pulses never start vertical sync.
- R4: Each vertical sync pulse keeps vsync_n low for exactly 3*P clock cycles.
- R5: Only the first broad pulse of an interval starts vertical sync. Detection is re-armed by the first narrow pulse that ends after vsync_n has returned high, so each interval yields exactly one pulse.
- R6: The phase of an interval is taken from where the falling edge of its first broad pulse lies on the line grid. A position in [P/4, 3P/4) is mid-line, which is field 2. Any other position is the line boundary, which is field 1. When the source is interlaced, field_odd is 1 for field 1 and 0 for field 2.
- R7: At each vertical sync leading edge, interlaced becomes 1 if this interval's phase differs from the previous interval's, and 0 if it is the same. The first interval after reset or a timeout leaves interlaced unchanged.
- R8: While interlaced is 0, field_odd is 1. field_odd changes only at a vertical sync leading edge or a timeout.
- R9: locked rises at the leading edge of the second vertical sync after reset or a timeout.
- R10: If a period is known and no sync edge arrives for 4*P cycles, every output returns to its reset value and the learned period is dropped.
- R11: Once P is known, a narrow pulse whose gap from the previous falling edge is below 3P/4 (an equalizing pulse, or the first pulse after an interval) neither changes P nor moves the line grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sampled composite sync, low during sync pulses |
| vsync_n | output | 1 | Vertical sync, active low, 3 line periods long |
| field_odd | output | 1 | 1 during field 1 or for a progressive source, 0 during field 2 |
| interlaced | output | 1 | 1 when successive vertical intervals alternate in half-line phase |
| locked | output | 1 | 1 after two vertical intervals with no timeout between them |

## Verification
The main stimulus is a clean 64-cycle line grid. Vertical intervals are inserted either on a line boundary or half a line late, in a fixed phase sequence. Alternating phases separate interlaced from progressive decisions, and repeated phases check the return to progressive with field_odd forced high. Each interval also checks that exactly one vertical pulse appears, that it has the exact width, and that it starts inside a broad pulse. A lone long pulse before learning, a burst of half-line equalizing pulses, and a silent stream check that learning is guarded, that short gaps are ignored, and that the timeout clears everything.

// File: rtl/vsd_pkg.sv
`timescale 1ns/1ps
package vsd_pkg;

  typedef struct packed {
    logic fall;
    logic rise;
    logic low;
  } sync_evt_t;

  function automatic int unsigned wrap_inc(input int unsigned pos, input int unsigned per);
    return (pos + 1 >= per) ? 0 : pos + 1;
  endfunction

  function automatic bit broad_len(input int unsigned len, input int unsigned per);
    return len > (per >> 2);
  endfunction

  function automatic bit mid_phase(input int unsigned pos, input int unsigned per);
    return (pos >= (per >> 2)) && (pos < per - (per >> 2));
  endfunction

  function automatic bit close_enough(input int unsigned a, input int unsigned b,
                                      input int unsigned tol);
    return ((a > b) ? a - b : b - a) <= tol;
  endfunction

  function automatic bit short_gap(input int unsigned m, input int unsigned per);
    return m < per - (per >> 2);
  endfunction

  function automatic int unsigned vs_len(input int unsigned per);
    return 3 * per;
  endfunction

  function automatic int unsigned quiet_limit(input int unsigned per);
    return per << 2;
  endfunction

endpackage

// File: rtl/vsd_pulse_timer.sv
`timescale 1ns/1ps
module vsd_pulse_timer
  import vsd_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csync_n,
  output sync_evt_t          evt,
  output logic [CNT_W-1:0]   low_len,
  output logic [CNT_W-1:0]   last_gap,
  output logic               gap_ok,
  output logic [CNT_W+1:0]   quiet
);
  localparam logic [CNT_W-1:0] LMAX = '1;
  localparam logic [CNT_W+1:0] QMAX = '1;

  logic s_q, s_d;
  logic [CNT_W-1:0] gap_cnt;

  always_comb begin
    evt.fall = s_d & ~s_q;
    evt.rise = ~s_d & s_q;
    evt.low  = ~s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q      <= 1'b1;
      s_d      <= 1'b1;
      low_len  <= '0;
      gap_cnt  <= '0;
      last_gap <= '0;
      gap_ok   <= 1'b0;
      quiet    <= '0;
    end else begin
      s_q <= csync_n;
      s_d <= s_q;
      if (evt.fall) low_len <= CNT_W'(1);
      else if (!s_q && low_len != LMAX) low_len <= low_len + 1'b1;
      if (evt.fall) begin
        last_gap <= gap_cnt;
        gap_ok   <= (gap_cnt != '0) && (gap_cnt != LMAX);
        gap_cnt  <= CNT_W'(1);
      end else if (gap_cnt != '0 && gap_cnt != LMAX) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
      if (evt.fall || evt.rise) quiet <= '0;
      else if (quiet != QMAX) quiet <= quiet + 1'b1;
    end
  end

  // every rising edge closes a pulse whose low time was counted
  assert_rise_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |-> (low_len != '0))
    else $error("rise without counted low time");

endmodule

// File: rtl/vsd_period_learner.sv
`timescale 1ns/1ps
module vsd_period_learner
  import vsd_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned TOL        = 4,
  parameter int unsigned MIN_PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_normal,
  input  logic [CNT_W-1:0] meas,
  input  logic             meas_ok,
  input  logic             clear,
  output logic [CNT_W-1:0] period,
  output logic             period_ok
);
  logic [CNT_W-1:0] cand;
  logic             cand_ok;
  logic             take, agree;

  always_comb begin
    take  = rise_normal && meas_ok && (32'(meas) >= MIN_PERIOD) &&
            !(period_ok && short_gap(32'(meas), 32'(period)));
    agree = cand_ok && close_enough(32'(meas), 32'(cand), TOL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand      <= '0;
      cand_ok   <= 1'b0;
      period    <= '0;
      period_ok <= 1'b0;
    end else if (clear) begin
      cand_ok   <= 1'b0;
      period_ok <= 1'b0;
    end else if (take) begin
      cand    <= meas;
      cand_ok <= 1'b1;
      if (agree) begin
        period    <= meas;
        period_ok <= 1'b1;
      end
    end
  end

  assert_learn_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_ok) |-> $past(rise_normal))
    else $error("period learned without a narrow pulse");

  assert_period_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_ok |-> (32'(period) >= MIN_PERIOD))
    else $error("learned period below floor");

endmodule

// File: rtl/vsd_line_phase.sv
`timescale 1ns/1ps
module vsd_line_phase
  import vsd_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_ev,
  input  logic             rise_normal,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] last_gap,
  input  logic             gap_ok,
  input  logic [CNT_W-1:0] period,
  input  logic             period_ok,
  output logic [CNT_W-1:0] fall_pos
);
  logic [CNT_W-1:0] line_pos, pos_next;
  logic             realign;

  always_comb begin
    pos_next = CNT_W'(wrap_inc(32'(line_pos), 32'(period)));
    realign  = rise_normal &&
               (!gap_ok || !period_ok || !short_gap(32'(last_gap), 32'(period)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_pos <= '0;
      fall_pos <= '0;
    end else begin
      if (realign) line_pos <= (low_len < period) ? low_len : '0;
      else         line_pos <= pos_next;
      if (fall_ev) fall_pos <= pos_next;
    end
  end

  // grid position stays inside one learned line
  assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_ok && $past(period_ok) && $stable(period)) |=> (line_pos < period))
    else $error("line position outside learned period");

endmodule

// File: rtl/vsd_vertical_ctrl.sv
`timescale 1ns/1ps
module vsd_vertical_ctrl
  import vsd_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sync_evt_t        evt,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W+1:0] quiet,
  input  logic [CNT_W-1:0] period,
  input  logic             period_ok,
  input  logic [CNT_W-1:0] fall_pos,
  output logic             rise_normal,
  output logic             timeout,
  output logic             vsync_n,
  output logic             field_odd,
  output logic             interlaced,
  output logic             locked
);
  logic             pulse_broad, armed, have_prev, prev_mid, seen;
  logic [CNT_W+1:0] vs_cnt;
  logic             broad_now, trig, phase_mid, ilace_next;

  always_comb begin
    broad_now   = evt.low && !evt.fall && period_ok && !pulse_broad &&
                  broad_len(32'(low_len), 32'(period));
    trig        = broad_now && armed;
    rise_normal = evt.rise && !pulse_broad;
    timeout     = period_ok && (32'(quiet) >= quiet_limit(32'(period)));
    phase_mid   = mid_phase(32'(fall_pos), 32'(period));
    ilace_next  = have_prev ? (phase_mid != prev_mid) : interlaced;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_broad <= 1'b0;
      armed       <= 1'b1;
      have_prev   <= 1'b0;
      prev_mid    <= 1'b0;
      seen        <= 1'b0;
      vs_cnt      <= '0;
      vsync_n     <= 1'b1;
      field_odd   <= 1'b1;
      interlaced  <= 1'b0;
      locked      <= 1'b0;
    end else if (timeout) begin
      pulse_broad <= 1'b0;
      armed       <= 1'b1;
      have_prev   <= 1'b0;
      prev_mid    <= 1'b0;
      seen        <= 1'b0;
      vs_cnt      <= '0;
      vsync_n     <= 1'b1;
      field_odd   <= 1'b1;
      interlaced  <= 1'b0;
      locked      <= 1'b0;
    end else begin
      if (evt.fall)      pulse_broad <= 1'b0;
      else if (broad_now) pulse_broad <= 1'b1;

      if (trig)                        armed <= 1'b0;
      else if (rise_normal && vsync_n) armed <= 1'b1;

      if (trig) begin
        vsync_n    <= 1'b0;
        vs_cnt     <= (CNT_W+2)'(vs_len(32'(period)) - 1);
        interlaced <= ilace_next;
        field_odd  <= ilace_next ? !phase_mid : 1'b1;
        prev_mid   <= phase_mid;
        have_prev  <= 1'b1;
        seen       <= 1'b1;
        locked     <= locked | seen;
      end else if (!vsync_n) begin
        if (vs_cnt == '0) vsync_n <= 1'b1;
        else              vs_cnt  <= vs_cnt - 1'b1;
      end
    end
  end

  assert_vs_in_broad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(evt.low))
    else $error("vertical sync started outside a sync pulse");

  assert_field_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_odd) |-> ($fell(vsync_n) || $past(timeout)))
    else $error("field flag moved away from vertical sync");

  assert_prog_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !interlaced |-> field_odd)
    else $error("progressive source with low field flag");

  assert_lock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $fell(vsync_n))
    else $error("lock rose away from vertical sync");

  assert_lock_learn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> period_ok)
    else $error("locked without a learned period");

  assert_quiet_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(timeout) |-> (!locked && vsync_n && !interlaced && field_odd))
    else $error("timeout did not clear outputs");

endmodule

// File: rtl/vsync_field_detector.sv
`timescale 1ns/1ps
module vsync_field_detector
  import vsd_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned TOL        = 4,
  parameter int unsigned MIN_PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic vsync_n,
  output logic field_odd,
  output logic interlaced,
  output logic locked
);
  sync_evt_t        evt;
  logic [CNT_W-1:0] low_len, last_gap, period, fall_pos;
  logic [CNT_W+1:0] quiet;
  logic             gap_ok, period_ok, rise_normal, timeout;

  vsd_pulse_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .evt(evt),
    .low_len(low_len), .last_gap(last_gap), .gap_ok(gap_ok), .quiet(quiet)
  );

  vsd_period_learner #(.CNT_W(CNT_W), .TOL(TOL), .MIN_PERIOD(MIN_PERIOD)) learner_i (
    .clk(clk), .rst_n(rst_n), .rise_normal(rise_normal), .meas(last_gap),
    .meas_ok(gap_ok), .clear(timeout), .period(period), .period_ok(period_ok)
  );

  vsd_line_phase #(.CNT_W(CNT_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .fall_ev(evt.fall), .rise_normal(rise_normal),
    .low_len(low_len), .last_gap(last_gap), .gap_ok(gap_ok), .period(period),
    .period_ok(period_ok), .fall_pos(fall_pos)
  );

  vsd_vertical_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .low_len(low_len), .quiet(quiet),
    .period(period), .period_ok(period_ok), .fall_pos(fall_pos),
    .rise_normal(rise_normal), .timeout(timeout), .vsync_n(vsync_n),
    .field_odd(field_odd), .interlaced(interlaced), .locked(locked)
  );

endmodule

// File: tb/vsync_field_detector_tb.sv
`timescale 1ns/1ps
module vsync_field_detector_tb_top;
  localparam int H = 64;

  // [3] interval starts mid-line, [2] field_odd, [1] interlaced, [0] locked
  localparam logic [3:0] VEC [8] = '{4'b0100, 4'b1011, 4'b0111, 4'b1011,
                                     4'b1101, 4'b1101, 4'b0111, 4'b1011};

  logic clk = 1'b0;
  logic rst_n, csync_n;
  logic vsync_n, field_odd, interlaced, locked;
  int n_chk = 0, n_fail = 0;
  int vs_falls = 0, run = 0, last_width = 0, f0;
  logic vs_prev = 1'b1, cs_at_fall = 1'b1;

  always #2 clk = ~clk;

  vsync_field_detector dut_i (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .vsync_n(vsync_n),
    .field_odd(field_odd), .interlaced(interlaced), .locked(locked)
  );

  always @(negedge clk) begin
    if (vs_prev === 1'b1 && vsync_n === 1'b0) begin
      vs_falls   = vs_falls + 1;
      cs_at_fall = csync_n;
    end
    if (vsync_n === 1'b0) run = run + 1;
    if (vs_prev === 1'b0 && vsync_n === 1'b1) begin
      last_width = run;
      run = 0;
    end
    vs_prev = vsync_n;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    csync_n = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic line();
    drive(1'b0, 5);
    drive(1'b1, H - 5);
  endtask

  task automatic vert(input logic mid);
    if (mid) begin
      drive(1'b0, 5);
      drive(1'b1, H/2 - 5);
    end
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, 24);
      drive(1'b1, H/2 - 24);
    end
    if (mid) drive(1'b1, H/2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    csync_n = 1'b1;
    rst_n   = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "vsync_n after reset", int'(vsync_n), 1);
    check("R1", "field_odd after reset", int'(field_odd), 1);
    check("R1", "interlaced after reset", int'(interlaced), 0);
    check("R1", "locked after reset", int'(locked), 0);

    // R2: a long pulse before any period is learned starts nothing
    f0 = vs_falls;
    line();
    line();
    drive(1'b0, 30);
    drive(1'b1, H - 30);
    check("R2", "vsync before learning", vs_falls - f0, 0);

    repeat (8) line();
    for (int i = 0; i < 8; i++) begin
      f0 = vs_falls;
      vert(VEC[i][3]);
      repeat (6) line();
      check("R5", "vsync pulses per interval", vs_falls - f0, 1);
      check("R4", "vsync width", last_width, 3 * H);
      check("R3", "csync low at vsync start", int'(cs_at_fall), 0);
      check(VEC[i][1] ? "R6" : "R8", "field_odd", int'(field_odd), int'(VEC[i][2]));
      check("R7", "interlaced", int'(interlaced), int'(VEC[i][1]));
      check("R9", "locked", int'(locked), int'(VEC[i][0]));
    end

    // R11: half-line equalizing pulses leave the period and grid alone
    repeat (3) line();
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, 3);
      drive(1'b1, H/2 - 3);
    end
    f0 = vs_falls;
    repeat (4) line();
    check("R3", "narrow pulses start no vsync", vs_falls - f0, 0);
    vert(1'b0);
    repeat (6) line();
    check("R11", "vsync width after equalizing", last_width, 3 * H);
    check("R11", "one pulse after equalizing", vs_falls - f0, 1);
    check("R6", "field_odd boundary phase", int'(field_odd), 1);
    check("R7", "interlaced after phase change", int'(interlaced), 1);

    // R10: silence for more than four lines
    drive(1'b1, 4 * H + 20);
    check("R10", "locked after silence", int'(locked), 0);
    check("R10", "interlaced after silence", int'(interlaced), 0);
    check("R10", "field_odd after silence", int'(field_odd), 1);
    check("R10", "vsync_n after silence", int'(vsync_n), 1);
    f0 = vs_falls;
    drive(1'b0, 30);
    drive(1'b1, H);
    check("R10", "long pulse after period dropped", vs_falls - f0, 0);
    check("R10", "still unlocked", int'(locked), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule